// File: doc/BRIEF.md
# Snapshot-Driven Reaction Engine

This block runs one reaction at a time for a small state machine whose transitions come from a table supplied on input ports. Each input channel is a pending-event flag with a data word. The upstream buffer clears the flag when the engine pulses that channel's consume strobe. Each output channel is a data register with a one-cycle emit strobe. A reaction goes through four phases in a fixed order. The engine waits idle, then captures every pending flag in the same cycle, then resolves and applies one transition, then emits.

A table entry names the events it requires, the state it applies in, the state it leads to, the outputs it drives and one data constant. The outgoing data word is that constant XOR the data of the lowest-numbered input the entry requires. If no entry applies, the reaction leaves everything untouched, including the pending events. Output data always settles one cycle before its strobe. After reset the engine makes one transition into a configurable start state without waiting for an event.

Top module: `evt_react_core`

## Requirements
- R1: `busy_o` rises only in the cycle after a cycle in which at least one `ev_present_i` bit was high while idle. It then stays high for exactly three cycles: detect, execute, emit.
- R2: The snapshot is the value of `ev_present_i` at the edge that leaves idle. Bits that rise after that edge are neither matched nor consumed by that reaction.
- R3: While idle with all `ev_present_i` bits low, the engine stays idle and drives no consume or emit strobe.
- R4: After reset, `busy_o` is high for one cycle with `state_o` = 0, `out_data_o` = 0 and no strobes. In the following cycle `state_o` equals `INIT_STATE` and `busy_o` is low, with no input event needed.
- R5: Entry e matches when its input mask is nonzero, every bit of that mask is set in the snapshot, and its present-state field equals the current state. The lowest matching index is selected.
- R6: On a match, `consume_o` equals the snapshot during the execute cycle (the second busy cycle) and is zero in every other cycle. `state_o` shows the entry's next state from the emit cycle on.
- R7: With no match, `consume_o` and `out_emit_o` stay zero, and `state_o` and `out_data_o` keep their values.
- R8: An entry whose output mask is zero and whose next state equals its present state still consumes the snapshot. It emits nothing and leaves all output data unchanged.
- R9: On a match, each output in the entry's output mask takes the entry's data constant XOR the input data of the lowest set bit of the entry's input mask. That input data is sampled at the end of the detect cycle, after the snapshot. The new value appears in the execute cycle, one cycle before the emit. Outputs outside the mask hold their value.
- R10: `out_emit_o` equals the matched entry's output mask during the emit cycle (the third busy cycle) only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_present_i | input | NI | Pending-event flag per input channel |
| ev_data_i | input | NI*DW | Data word per input channel, channel i at bits i*DW |
| consume_o | output | NI | One-cycle strobe telling the buffer to clear the flag |
| tbl_in_mask_i | input | NE*NI | Required-event mask per entry |
| tbl_cur_st_i | input | NE*SW | Present-state field per entry |
| tbl_nxt_st_i | input | NE*SW | Next-state field per entry |
| tbl_out_mask_i | input | NE*NO | Output-channel mask per entry |
| tbl_out_data_i | input | NE*DW | Output data constant per entry |
| out_data_o | output | NO*DW | Data register per output channel |
| out_emit_o | output | NO | One-cycle emit strobe per output channel |
| state_o | output | SW | Current state |
| busy_o | output | 1 | High outside the idle phase |

## Verification
The bench attacks the gap between event capture and data read. It raises an extra event after the snapshot has been taken, and it changes the input data during the detect cycle. A design that resamples events would consume the late event. A design that reads data together with the events would produce the stale word. Overlapping entries test the priority rule, where a design with inverted priority lands in the wrong state. A trivial entry and an unmatched snapshot cover the two ways of doing nothing. A design that confuses them either drops events it should keep or keeps events it should drop. A long pseudo-random sweep of snapshots across every reachable state compares each reaction's consume, data, emit and state against an arithmetic model.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [2:0] {
    PH_INIT   = 3'd0,
    PH_IDLE   = 3'd1,
    PH_DETECT = 3'd2,
    PH_EXEC   = 3'd3,
    PH_EMIT   = 3'd4
  } phase_e;
endpackage

// File: rtl/evr_phase.sv
module evr_phase
  import evr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   any_ev_i,
  output phase_e phase_o
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase_o;
    unique case (phase_o)
      PH_INIT:   phase_d = PH_IDLE;
      PH_IDLE:   if (any_ev_i) phase_d = PH_DETECT;
      PH_DETECT: phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_EMIT;
      PH_EMIT:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= PH_INIT;
    else         phase_o <= phase_d;
  end
endmodule

// File: rtl/evr_match.sv
module evr_match #(
  parameter int NI   = 4,
  parameter int SW   = 3,
  parameter int NE   = 8,
  localparam int IW   = (NE > 1) ? $clog2(NE) : 1,
  localparam int SELW = (NI > 1) ? $clog2(NI) : 1
) (
  input  logic [NI-1:0]    snap_i,
  input  logic [SW-1:0]    state_i,
  input  logic [NE*NI-1:0] in_mask_i,
  input  logic [NE*SW-1:0] cur_st_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o,
  output logic [SELW-1:0]  sel_o
);
  logic [NE-1:0] hit_vec;
  logic [NI-1:0] win_mask;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    logic [NI-1:0] m;
    assign m = in_mask_i[e*NI +: NI];
    assign hit_vec[e] = (|m) && ((snap_i & m) == m) &&
                        (cur_st_i[e*SW +: SW] == state_i);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (hit_vec[e]) idx_o = IW'(e);
    end
  end

  assign hit_o    = |hit_vec;
  assign win_mask = in_mask_i[idx_o*NI +: NI];

  // data source: lowest required input of the winning entry
  always_comb begin
    sel_o = '0;
    for (int i = NI - 1; i >= 0; i--) begin
      if (win_mask[i]) sel_o = SELW'(i);
    end
  end
endmodule

// File: rtl/evr_outregs.sv
module evr_outregs #(
  parameter int NO = 4,
  parameter int DW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [NO-1:0]  wr_mask_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           emit_en_i,
  input  logic [NO-1:0]  emit_mask_i,
  output logic [NO*DW-1:0] data_o,
  output logic [NO-1:0]  emit_o
);
  for (genvar o = 0; o < NO; o++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[o*DW +: DW] <= '0;
        emit_o[o]          <= 1'b0;
      end else begin
        if (wr_en_i && wr_mask_i[o]) data_o[o*DW +: DW] <= wr_data_i;
        emit_o[o] <= emit_en_i && emit_mask_i[o];
      end
    end
  end
endmodule

// File: rtl/evt_react_core.sv
module evt_react_core
  import evr_pkg::*;
#(
  parameter int NI         = 4,
  parameter int NO         = 4,
  parameter int DW         = 8,
  parameter int SW         = 3,
  parameter int NE         = 8,
  parameter int INIT_STATE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NI-1:0]    ev_present_i,
  input  logic [NI*DW-1:0] ev_data_i,
  output logic [NI-1:0]    consume_o,
  input  logic [NE*NI-1:0] tbl_in_mask_i,
  input  logic [NE*SW-1:0] tbl_cur_st_i,
  input  logic [NE*SW-1:0] tbl_nxt_st_i,
  input  logic [NE*NO-1:0] tbl_out_mask_i,
  input  logic [NE*DW-1:0] tbl_out_data_i,
  output logic [NO*DW-1:0] out_data_o,
  output logic [NO-1:0]    out_emit_o,
  output logic [SW-1:0]    state_o,
  output logic             busy_o
);
  localparam int IW   = (NE > 1) ? $clog2(NE) : 1;
  localparam int SELW = (NI > 1) ? $clog2(NI) : 1;

  phase_e          phase_q;
  logic [NI-1:0]   snap_q;
  logic [SW-1:0]   state_q, nxt_q;
  logic [NO-1:0]   omask_q;
  logic            hit_q;
  logic            m_hit;
  logic [IW-1:0]   m_idx;
  logic [SELW-1:0] m_sel;
  logic            in_detect, in_exec;
  logic [DW-1:0]   wr_data;

  evr_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_ev_i (|ev_present_i),
    .phase_o  (phase_q)
  );

  evr_match #(.NI(NI), .SW(SW), .NE(NE)) u_match (
    .snap_i    (snap_q),
    .state_i   (state_q),
    .in_mask_i (tbl_in_mask_i),
    .cur_st_i  (tbl_cur_st_i),
    .hit_o     (m_hit),
    .idx_o     (m_idx),
    .sel_o     (m_sel)
  );

  assign in_detect = (phase_q == PH_DETECT);
  assign in_exec   = (phase_q == PH_EXEC);
  // data is read after the event snapshot, at the end of detect
  assign wr_data   = tbl_out_data_i[m_idx*DW +: DW] ^ ev_data_i[m_sel*DW +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      state_q <= '0;
      nxt_q   <= '0;
      omask_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (phase_q == PH_IDLE && |ev_present_i) snap_q <= ev_present_i;
      if (in_detect) begin
        hit_q   <= m_hit;
        nxt_q   <= tbl_nxt_st_i[m_idx*SW +: SW];
        omask_q <= m_hit ? tbl_out_mask_i[m_idx*NO +: NO] : '0;
      end
      if (phase_q == PH_INIT)   state_q <= SW'(INIT_STATE);
      else if (in_exec && hit_q) state_q <= nxt_q;
    end
  end

  evr_outregs #(.NO(NO), .DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (in_detect && m_hit),
    .wr_mask_i   (tbl_out_mask_i[m_idx*NO +: NO]),
    .wr_data_i   (wr_data),
    .emit_en_i   (in_exec && hit_q),
    .emit_mask_i (omask_q),
    .data_o      (out_data_o),
    .emit_o      (out_emit_o)
  );

  assign consume_o = (in_exec && hit_q) ? snap_q : '0;
  assign state_o   = state_q;
  assign busy_o    = (phase_q != PH_IDLE);
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
  parameter int NI = 4,
  parameter int NO = 4,
  parameter int DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NI-1:0]    ev_present_i,
  input logic [NI-1:0]    consume_o,
  input logic [NO*DW-1:0] out_data_o,
  input logic [NO-1:0]    out_emit_o,
  input logic             busy_o
);
  AST_START_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(ev_present_i) != '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ev_present_i == '0) |=> (!busy_o && consume_o == '0)); // R3

  AST_CONSUME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_o != '0) |=> (consume_o == '0 && busy_o)); // R6

  AST_CONSUME_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_o != '0) |-> busy_o); // R6

  AST_DATA_BEFORE_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_emit_o != '0) |-> $stable(out_data_o)); // R9

  AST_EMIT_AFTER_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_emit_o != '0) |-> ($past(consume_o) != '0)); // R10

  AST_EMIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_emit_o != '0) |=> (out_emit_o == '0 && !busy_o)); // R10
endmodule

bind evt_react_core evr_checker #(.NI(NI), .NO(NO), .DW(DW)) u_evr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ev_present_i (ev_present_i),
  .consume_o    (consume_o),
  .out_data_o   (out_data_o),
  .out_emit_o   (out_emit_o),
  .busy_o       (busy_o)
);

// File: tb/evt_react_core_tb.sv
module evt_react_core_tb_top;
  localparam int NI = 4, NO = 4, DW = 8, SW = 3, NE = 8, INIT_ST = 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NI-1:0]    ev_present = '0;
  logic [NI*DW-1:0] ev_data = '0;
  logic [NI-1:0]    consume;
  logic [NE*NI-1:0] t_in;
  logic [NE*SW-1:0] t_cur, t_nxt;
  logic [NE*NO-1:0] t_om;
  logic [NE*DW-1:0] t_od;
  logic [NO*DW-1:0] out_data;
  logic [NO-1:0]    out_emit;
  logic [SW-1:0]    state;
  logic             busy;

  int checks = 0, fails = 0, cyc = 0;

  // table: in_mask, cur, nxt, out_mask, out_data
  logic [NI-1:0] e_in  [NE] = '{4'b0011, 4'b0001, 4'b0100, 4'b1000, 4'b0010, 4'b1100, 4'b0001, 4'b0000};
  logic [SW-1:0] e_cur [NE] = '{3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd0, 3'd1};
  logic [SW-1:0] e_nxt [NE] = '{3'd2, 3'd3, 3'd2, 3'd1, 3'd1, 3'd0, 3'd1, 3'd0};
  logic [NO-1:0] e_om  [NE] = '{4'b0001, 4'b0110, 4'b0000, 4'b1000, 4'b1111, 4'b0101, 4'b0010, 4'b1111};
  logic [DW-1:0] e_od  [NE] = '{8'h11, 8'h22, 8'h00, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      t_in[e*NI +: NI]  = e_in[e];
      t_cur[e*SW +: SW] = e_cur[e];
      t_nxt[e*SW +: SW] = e_nxt[e];
      t_om[e*NO +: NO]  = e_om[e];
      t_od[e*DW +: DW]  = e_od[e];
    end
  end

  evt_react_core #(.NI(NI), .NO(NO), .DW(DW), .SW(SW), .NE(NE), .INIT_STATE(INIT_ST)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .ev_present_i (ev_present), .ev_data_i (ev_data), .consume_o (consume),
    .tbl_in_mask_i (t_in), .tbl_cur_st_i (t_cur), .tbl_nxt_st_i (t_nxt),
    .tbl_out_mask_i (t_om), .tbl_out_data_i (t_od),
    .out_data_o (out_data), .out_emit_o (out_emit), .state_o (state), .busy_o (busy)
  );

  always #10 clk = ~clk; // 50 MHz

  // model state
  logic [SW-1:0]    m_state;
  logic [NO*DW-1:0] m_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one reaction: snap presented in idle, late bits raised after capture,
  // input data swapped during detect (stale pre, fresh post)
  task automatic react(input logic [NI-1:0] snap, input logic [NI-1:0] late, input logic [7:0] seed);
    logic [NI*DW-1:0] fresh;
    bit hit;
    int idx, sel;
    logic [NO*DW-1:0] exp_data;
    for (int i = 0; i < NI; i++) fresh[i*DW +: DW] = DW'(seed * 7 + i * 29 + 3);
    hit = 0; idx = 0;
    for (int e = NE - 1; e >= 0; e--)
      if (e_in[e] != '0 && (snap & e_in[e]) == e_in[e] && e_cur[e] == m_state) begin
        hit = 1; idx = e;
      end
    sel = 0;
    for (int i = NI - 1; i >= 0; i--) if (e_in[idx][i]) sel = i;
    exp_data = m_data;
    if (hit)
      for (int o = 0; o < NO; o++)
        if (e_om[idx][o]) exp_data[o*DW +: DW] = e_od[idx] ^ fresh[sel*DW +: DW];

    @(negedge clk); // idle
    ev_present = snap;
    ev_data    = ~fresh;
    @(negedge clk); // detect
    chk(busy && consume == '0 && out_emit == '0, "R1 detect cycle", {busy, consume, out_emit}, {1'b1, 8'h0});
    ev_present = snap | late;
    ev_data    = fresh;
    @(negedge clk); // execute
    chk(consume == (hit ? snap : '0), hit ? "R6/R2 consume" : "R7 consume", consume, hit ? snap : '0);
    chk(out_data == exp_data, hit ? "R9 data before emit" : "R7 data held", out_data, exp_data);
    chk(out_emit == '0 && busy, "R10 no emit in execute", out_emit, 0);
    @(negedge clk); // emit
    chk(out_emit == (hit ? e_om[idx] : '0), hit ? "R10 emit mask" : "R7 no emit", out_emit, hit ? e_om[idx] : '0);
    chk(state == (hit ? e_nxt[idx] : m_state), hit ? "R6 next state" : "R7 state held", state, hit ? e_nxt[idx] : m_state);
    chk(out_data == exp_data, "R9 data stable at emit", out_data, exp_data);
    ev_present = '0;
    @(negedge clk); // idle
    chk(!busy && out_emit == '0 && consume == '0, "R1 back to idle", {busy, out_emit, consume}, 0);
    if (hit) m_state = e_nxt[idx];
    m_data = exp_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    m_state = '0;
    m_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4: initial transition cycle
    chk(busy && state == 3'd0 && out_data == '0 && consume == '0 && out_emit == '0,
        "R4 init cycle", {busy, state, consume, out_emit}, {1'b1, 3'd0, 8'h0});
    @(negedge clk);
    chk(!busy && state == SW'(INIT_ST), "R4 reached init state", {busy, state}, {1'b0, 3'(INIT_ST)});
    m_state = SW'(INIT_ST);
    // R3: no events, stay idle
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!busy && consume == '0 && out_emit == '0, "R3 idle without events", {busy, consume, out_emit}, 0);
    end
    // R5 priority: entries 0 and 1 both match in state 1, entry 0 wins -> state 2
    react(4'b0011, 4'b0000, 8'd1);
    chk(state == 3'd2, "R5 lowest index wins", state, 3'd2);
    // R8 trivial transition in state 2
    react(4'b0100, 4'b0000, 8'd2);
    chk(state == 3'd2, "R8 trivial keeps state", state, 3'd2);
    // R7 no match in state 2
    react(4'b0001, 4'b0000, 8'd3);
    // R2 late event after capture not consumed
    react(4'b1000, 4'b0110, 8'd4);
    chk(state == 3'd1, "R2 snapshot transition", state, 3'd1);
    // entry 7 (empty mask) never matches: state 1 with only bit 2
    react(4'b0100, 4'b0000, 8'd5);
    chk(state == 3'd1, "R5 empty-mask entry ignored", state, 3'd1);
    // sweep
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [NI-1:0] s;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = lf[3:0];
      if (s == '0) s = 4'b0001;
      react(s, lf[7:4] & ~s, lf[15:8]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule